// File: doc/BRIEF.md
# Video Timing Generator with Interlaced Fields

This block produces the raster timing for one display pipe from a single pixel clock. A small register port programs the four horizontal phase lengths in pixels and the four vertical phase lengths in lines. Each line and each frame runs through sync, back porch, active and front porch, in that order. From the running counters the block drives active-high horizontal and vertical sync, an active-video qualifier, a one-cycle frame-start pulse and a field indicator.

Interlaced output uses a second vertical register set. When interlace is on, successive fields alternate between the odd set and the even set, and the field indicator says which one is running. Software normally programs the even set with a back porch one line shorter than the odd set, and puts half the frame's active lines in each set. An interrupt flag marks the first cycle of the vertical front porch, so the next frame can be prepared during blanking.

The enable bit starts output. It can run for a single frame or repeat frames without software help. When software clears the enable bit, the current frame runs to its end. The enable bit keeps reading back as 1 until the output has actually stopped.

Top module: `vidTimingGen`

## Requirements
- R1: Every line runs, in order, sync for SW pixels, back porch for BP, active for AW and front porch for FP, so a line lasts SW+BP+AW+FP cycles. hSync is high for the SW cycles. Address 1 holds BP in bits [11:0] and SW in bits [27:16]. Address 2 holds FP in bits [11:0] and AW in bits [27:16].
- R2: Every frame runs vertical sync, back porch, active and front porch, using the same field layout (odd set at address 3 for back porch/sync and address 4 for front porch/active). vSync is high for whole sync lines, and activeVideo is high only where the horizontal and vertical phases are both active.
- R3: A phase length programmed as 0 lasts one pixel or one line, the same as a length of 1.
- R4: After reset all outputs are low and the registers read 0. Writing address 0 with bit 0 (enable) set starts a frame. frameStart is high for exactly the first cycle of each frame, and hSync and vSync are both high in that cycle.
- R5: With address 0 bit 1 (continuous) set, frames follow each other with no gap. With it clear, exactly one frame is produced, after which the enable bit reads 0.
- R6: Clearing the enable bit lets the current frame finish. Until the output has stopped, bit 0 of address 0 reads 1. After that it reads 0 and all timing outputs stay low.
- R7: With address 0 bit 2 (interlace) set, fieldId is 0 for the first frame after start and then alternates. A field with fieldId 1 takes its vertical timing from the even set (addresses 5 and 6, same layout as 3 and 4). With interlace clear, fieldId stays 0 and only the odd set is used.
- R8: Status bit 0 at address 7 is set in the first cycle of the vertical front porch. Writing 1 to it clears it, and writing 0 leaves it unchanged. irq equals that bit ANDed with address 0 bit 3 (interrupt enable).
- R9: Timing registers written while video runs take effect only from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rstN | input | 1 | active-low synchronous reset |
| regWr | input | 1 | register write strobe |
| regAddr | input | 3 | register address for write and read |
| regWData | input | 32 | register write data |
| regRData | output | 32 | register read data (combinational from regAddr) |
| hSync | output | 1 | horizontal sync, active high |
| vSync | output | 1 | vertical sync, active high |
| activeVideo | output | 1 | active picture area |
| frameStart | output | 1 | one-cycle pulse in a frame's first cycle |
| fieldId | output | 1 | current field: 0 odd set, 1 even set |
| irq | output | 1 | vertical front porch interrupt |

## Verification
The hardest situations to reach are the ones at a frame boundary while video is running. These are an enable bit cleared in mid-frame, a timing register rewritten in mid-frame, and the change from an odd field to a shorter even field. The stimulus enables continuous output and synchronises to frameStart. It then writes the register within the current frame and measures the lengths of the frame in progress and of the frames that follow, counting cycles between frameStart pulses. For the stop case, it polls the enable bit until it reads 0 and confirms that the outputs go quiet.

// File: rtl/vtgPkg.sv
package vtgPkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic launch;  // load shadows and restart counters at this edge
    logic run;     // counters advance, outputs valid
  } vtgStrobe_t;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_HA     = 3'd1;
  localparam logic [2:0] ADDR_HB     = 3'd2;
  localparam logic [2:0] ADDR_VODD_A = 3'd3;
  localparam logic [2:0] ADDR_VODD_B = 3'd4;
  localparam logic [2:0] ADDR_VEVN_A = 3'd5;
  localparam logic [2:0] ADDR_VEVN_B = 3'd6;
  localparam logic [2:0] ADDR_STAT   = 3'd7;
endpackage

// File: rtl/vtgDatapath.sv
module vtgDatapath
  import vtgPkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  vtgStrobe_t             ctl,
  input  logic [3:0][CNT_W-1:0]  hCfg,
  input  logic [3:0][CNT_W-1:0]  vCfg,
  output logic                   hSync,
  output logic                   vSync,
  output logic                   activeVideo,
  output logic                   frameEnd,
  output logic                   vfpEntry
);
  logic [3:0][CNT_W-1:0] hLen, vLen;
  logic [CNT_W-1:0] hCnt, vCnt;
  phase_t hPh, vPh, hNext, vNext;
  logic lineEnd;

  function automatic logic [CNT_W-1:0] lenLoad(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  assign hNext   = phase_t'(hPh + 2'd1);
  assign vNext   = phase_t'(vPh + 2'd1);
  assign lineEnd = ctl.run && hPh == PH_FRONT && hCnt == '0;
  assign frameEnd = lineEnd && vPh == PH_FRONT && vCnt == '0;
  assign vfpEntry = lineEnd && vPh == PH_ACT && vCnt == '0;

  assign hSync       = ctl.run && hPh == PH_SYNC;
  assign vSync       = ctl.run && vPh == PH_SYNC;
  assign activeVideo = ctl.run && hPh == PH_ACT && vPh == PH_ACT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hLen <= '0;
      vLen <= '0;
      hPh  <= PH_SYNC;
      vPh  <= PH_SYNC;
      hCnt <= '0;
      vCnt <= '0;
    end else if (ctl.launch) begin
      hLen <= hCfg;
      vLen <= vCfg;
      hPh  <= PH_SYNC;
      vPh  <= PH_SYNC;
      hCnt <= lenLoad(hCfg[PH_SYNC]);
      vCnt <= lenLoad(vCfg[PH_SYNC]);
    end else if (ctl.run) begin
      if (hCnt == '0) begin
        hPh  <= hNext;
        hCnt <= lenLoad(hLen[hNext]);
      end else begin
        hCnt <= hCnt - CNT_W'(1);
      end
      if (lineEnd) begin
        if (vCnt == '0) begin
          vPh  <= vNext;
          vCnt <= lenLoad(vLen[vNext]);
        end else begin
          vCnt <= vCnt - CNT_W'(1);
        end
      end
    end
  end

  // R4: after the last pixel a frame either restarts in sync or output stops
  assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (!ctl.run || (hSync && vSync)));

  // R2: the vertical phase only moves at the end of a line
  assert_vphase_at_line_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !ctl.launch && !lineEnd) |=> $stable(vPh));
endmodule

// File: rtl/vtgControl.sv
module vtgControl
  import vtgPkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic [2:0]             regAddr,
  input  logic [DATA_W-1:0]      regWData,
  output logic [DATA_W-1:0]      regRData,
  input  logic                   frameEnd,
  input  logic                   vfpEntry,
  output vtgStrobe_t             ctl,
  output logic [3:0][CNT_W-1:0]  hCfg,
  output logic [3:0][CNT_W-1:0]  vCfg,
  output logic                   frameStart,
  output logic                   fieldId,
  output logic                   irq
);
  localparam int HI_LSB = 16;

  logic enReq, contMode, ilace, irqEn, irqStat;
  logic running, fieldQ, vstartQ;
  logic [3:0][CNT_W-1:0] hReg, vOdd, vEvn;
  logic launch, stopNow, nextField, wrStat;
  logic unusedBits;

  assign unusedBits = ^regWData;
  assign launch    = enReq && (!running || (frameEnd && contMode));
  assign stopNow   = running && frameEnd && !(enReq && contMode);
  assign nextField = running ? (ilace & ~fieldQ) : 1'b0;
  assign wrStat    = regWr && regAddr == ADDR_STAT;

  assign ctl.launch = launch;
  assign ctl.run    = running;
  assign hCfg       = hReg;
  assign vCfg       = nextField ? vEvn : vOdd;
  assign frameStart = vstartQ;
  assign fieldId    = fieldQ;
  assign irq        = irqStat & irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReq <= 1'b0; contMode <= 1'b0; ilace <= 1'b0; irqEn <= 1'b0;
      irqStat <= 1'b0; running <= 1'b0; fieldQ <= 1'b0; vstartQ <= 1'b0;
      hReg <= '0; vOdd <= '0; vEvn <= '0;
    end else begin
      vstartQ <= launch;
      if (launch) begin
        running <= 1'b1;
        fieldQ  <= nextField;
      end else if (stopNow) begin
        running <= 1'b0;
        if (!contMode) enReq <= 1'b0;
      end
      irqStat <= (irqStat & ~(wrStat & regWData[0])) | vfpEntry;
      if (regWr) begin
        case (regAddr)
          ADDR_CTRL: begin
            enReq    <= regWData[0];
            contMode <= regWData[1];
            ilace    <= regWData[2];
            irqEn    <= regWData[3];
          end
          ADDR_HA: begin
            hReg[PH_BACK] <= regWData[CNT_W-1:0];
            hReg[PH_SYNC] <= regWData[HI_LSB+:CNT_W];
          end
          ADDR_HB: begin
            hReg[PH_FRONT] <= regWData[CNT_W-1:0];
            hReg[PH_ACT]   <= regWData[HI_LSB+:CNT_W];
          end
          ADDR_VODD_A: begin
            vOdd[PH_BACK] <= regWData[CNT_W-1:0];
            vOdd[PH_SYNC] <= regWData[HI_LSB+:CNT_W];
          end
          ADDR_VODD_B: begin
            vOdd[PH_FRONT] <= regWData[CNT_W-1:0];
            vOdd[PH_ACT]   <= regWData[HI_LSB+:CNT_W];
          end
          ADDR_VEVN_A: begin
            vEvn[PH_BACK] <= regWData[CNT_W-1:0];
            vEvn[PH_SYNC] <= regWData[HI_LSB+:CNT_W];
          end
          ADDR_VEVN_B: begin
            vEvn[PH_FRONT] <= regWData[CNT_W-1:0];
            vEvn[PH_ACT]   <= regWData[HI_LSB+:CNT_W];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRData = '0;
    case (regAddr)
      ADDR_CTRL:   regRData[3:0] = {irqEn, ilace, contMode, enReq | running};
      ADDR_HA:     begin regRData[CNT_W-1:0] = hReg[PH_BACK];  regRData[HI_LSB+:CNT_W] = hReg[PH_SYNC]; end
      ADDR_HB:     begin regRData[CNT_W-1:0] = hReg[PH_FRONT]; regRData[HI_LSB+:CNT_W] = hReg[PH_ACT];  end
      ADDR_VODD_A: begin regRData[CNT_W-1:0] = vOdd[PH_BACK];  regRData[HI_LSB+:CNT_W] = vOdd[PH_SYNC]; end
      ADDR_VODD_B: begin regRData[CNT_W-1:0] = vOdd[PH_FRONT]; regRData[HI_LSB+:CNT_W] = vOdd[PH_ACT];  end
      ADDR_VEVN_A: begin regRData[CNT_W-1:0] = vEvn[PH_BACK];  regRData[HI_LSB+:CNT_W] = vEvn[PH_SYNC]; end
      ADDR_VEVN_B: begin regRData[CNT_W-1:0] = vEvn[PH_FRONT]; regRData[HI_LSB+:CNT_W] = vEvn[PH_ACT];  end
      default:     regRData[0] = irqStat;
    endcase
  end

  // R6: output only stops at the end of a frame
  assert_stop_at_frame_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(frameEnd));

  // R7: the field indicator only changes together with a frame start
  assert_field_at_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fieldQ) |-> vstartQ);

  // R8: the status flag is raised only by the front porch entry
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStat) |-> $past(vfpEntry));

  // R4: a frame start pulse only occurs while video runs
  assert_start_while_running_R4: assert property (@(posedge clk) disable iff (!rstN)
    vstartQ |-> running);
endmodule

// File: rtl/vidTimingGen.sv
module vidTimingGen
  import vtgPkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWData,
  output logic [31:0] regRData,
  output logic        hSync,
  output logic        vSync,
  output logic        activeVideo,
  output logic        frameStart,
  output logic        fieldId,
  output logic        irq
);
  vtgStrobe_t ctl;
  logic [3:0][CNT_W-1:0] hCfg, vCfg;
  logic frameEnd, vfpEntry;

  vtgControl #(.CNT_W(CNT_W), .DATA_W(32)) uCtl (
    .clk, .rstN, .regWr, .regAddr, .regWData, .regRData,
    .frameEnd, .vfpEntry, .ctl, .hCfg, .vCfg,
    .frameStart, .fieldId, .irq
  );

  vtgDatapath #(.CNT_W(CNT_W)) uDp (
    .clk, .rstN, .ctl, .hCfg, .vCfg,
    .hSync, .vSync, .activeVideo, .frameEnd, .vfpEntry
  );
endmodule

// File: tb/tb_vidTimingGen.sv
module tb_vidTimingGen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic hSync, vSync, activeVideo, frameStart, fieldId, irq;

  int nChk = 0;
  int nFail = 0;
  int cycCount = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cycCount <= cycCount + 1;

  vidTimingGen dut (
    .clk, .rstN, .regWr, .regAddr, .regWData, .regRData,
    .hSync, .vSync, .activeVideo, .frameStart, .fieldId, .irq
  );

  // stimulus vectors: hs, hb, ha, hf, vs, vb, va, vf
  localparam int NV = 4;
  localparam int VEC[NV][8] = '{
    '{2, 3, 5, 2, 1, 2, 4, 2},
    '{0, 1, 3, 0, 1, 0, 2, 1},
    '{4, 2, 8, 3, 2, 1, 6, 3},
    '{1, 1, 1, 1, 3, 2, 10, 1}
  };

  function automatic int len1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRData;
  endtask

  task automatic progV(input logic [2:0] base, input int vs, input int vb, input int va, input int vf);
    wr(base, 32'((vs << 16) | vb));
    wr(base + 3'd1, 32'((va << 16) | vf));
  endtask

  // measures one frame starting at the next (or current) frameStart
  task automatic measureFrame(output int len, output int nAct, output int nHs, output int nVs,
                              output int irqIdx, output int fld, output int syncAtStart,
                              output int startCyc);
    int g = 0;
    while (!frameStart && g < 20000) begin @(negedge clk); g++; end
    len = 0; nAct = 0; nHs = 0; nVs = 0; irqIdx = -1;
    fld = int'(fieldId); syncAtStart = int'(hSync && vSync); startCyc = cycCount;
    if (!frameStart) begin
      check("measure timeout (R4)", 0, 1);
      return;
    end
    for (int c = 0; c < 20000; c++) begin
      if (c > 0 && frameStart) break;
      if (activeVideo) nAct++;
      if (hSync) nHs++;
      if (vSync) nVs++;
      if (irq && irqIdx < 0) irqIdx = c;
      len++;
      @(negedge clk);
    end
  endtask

  task automatic waitStopped(output int stopped);
    logic [31:0] d;
    stopped = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd0, d);
      if (d[0] == 1'b0) begin stopped = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int len, nAct, nHs, nVs, irqIdx, fld, syn, t0, t1, stopped, nStarts, quiet;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state (R4)
    check("R4 reset hSync", int'(hSync), 0);
    check("R4 reset vSync", int'(vSync), 0);
    check("R4 reset activeVideo", int'(activeVideo), 0);
    check("R4 reset irq", int'(irq), 0);
    rd(3'd0, d); check("R4 reset ctrl readback", int'(d), 0);
    rd(3'd1, d); check("R4 reset timing readback", int'(d), 0);

    // table walk: R1, R2, R3, R4, R5, R6, R8
    for (int v = 0; v < NV; v++) begin
      int ll, vl;
      ll = len1(VEC[v][0]) + len1(VEC[v][1]) + len1(VEC[v][2]) + len1(VEC[v][3]);
      vl = len1(VEC[v][4]) + len1(VEC[v][5]) + len1(VEC[v][6]) + len1(VEC[v][7]);
      wr(3'd1, 32'((VEC[v][0] << 16) | VEC[v][1]));
      wr(3'd2, 32'((VEC[v][2] << 16) | VEC[v][3]));
      progV(3'd3, VEC[v][4], VEC[v][5], VEC[v][6], VEC[v][7]);
      wr(3'd7, 32'd1);
      wr(3'd0, 32'b1011);  // enable, continuous, irq enable
      measureFrame(len, nAct, nHs, nVs, irqIdx, fld, syn, t0);
      check($sformatf("R1 R3 frame length vec%0d", v), len, ll * vl);
      check($sformatf("R1 hSync cycles vec%0d", v), nHs, len1(VEC[v][0]) * vl);
      check($sformatf("R2 vSync cycles vec%0d", v), nVs, len1(VEC[v][4]) * ll);
      check($sformatf("R2 active cycles vec%0d", v), nAct, len1(VEC[v][2]) * len1(VEC[v][6]));
      check($sformatf("R8 irq at front porch vec%0d", v), irqIdx,
            ll * (len1(VEC[v][4]) + len1(VEC[v][5]) + len1(VEC[v][6])));
      check($sformatf("R4 sync at frame start vec%0d", v), syn, 1);
      check($sformatf("R7 field 0 without interlace vec%0d", v), fld, 0);
      wr(3'd0, 32'b1010);  // clear enable mid-frame
      rd(3'd0, d); check($sformatf("R6 enable reads 1 while finishing vec%0d", v), int'(d[0]), 1);
      waitStopped(stopped);
      check($sformatf("R6 stopped vec%0d", v), stopped, 1);
      quiet = 1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (hSync || vSync || activeVideo || frameStart) quiet = 0;
      end
      check($sformatf("R6 outputs idle vec%0d", v), quiet, 1);
      wr(3'd7, 32'd1);
    end

    // interlace: R7, R8 gating and W1C
    wr(3'd1, 32'((1 << 16) | 1));
    wr(3'd2, 32'((2 << 16) | 1));    // L = 5
    progV(3'd3, 1, 2, 3, 1);         // odd 7 lines
    progV(3'd5, 1, 1, 3, 1);         // even 6 lines
    wr(3'd0, 32'b0111);              // enable, continuous, interlace, irq off
    measureFrame(len, nAct, nHs, nVs, irqIdx, fld, syn, t0);
    check("R7 first field id", fld, 0);
    check("R7 odd field length", len, 35);
    check("R8 irq masked when disabled", irqIdx, -1);
    measureFrame(len, nAct, nHs, nVs, irqIdx, fld, syn, t0);
    check("R7 second field id", fld, 1);
    check("R7 even field length", len, 30);
    measureFrame(len, nAct, nHs, nVs, irqIdx, fld, syn, t0);
    check("R7 third field id", fld, 0);
    check("R7 third field length", len, 35);
    rd(3'd7, d); check("R8 status set while masked", int'(d[0]), 1);
    wr(3'd0, 32'b0000);
    waitStopped(stopped);
    check("R6 stopped after interlace", stopped, 1);
    wr(3'd7, 32'd0);
    rd(3'd7, d); check("R8 write 0 keeps status", int'(d[0]), 1);
    wr(3'd7, 32'd1);
    rd(3'd7, d); check("R8 write 1 clears status", int'(d[0]), 0);

    // single frame mode: R5
    wr(3'd0, 32'b0001);
    nStarts = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (frameStart) nStarts++;
    end
    check("R5 single frame count", nStarts, 1);
    rd(3'd0, d); check("R5 enable cleared after single frame", int'(d[0]), 0);
    check("R5 idle after single frame", int'(hSync || vSync || activeVideo), 0);

    // mid-frame register change: R9
    wr(3'd0, 32'b0011);
    measureFrame(len, nAct, nHs, nVs, irqIdx, fld, syn, t0);
    t0 = cycCount - len;  // start of the frame just measured is not needed; restart sync
    measureFrame(len, nAct, nHs, nVs, irqIdx, fld, syn, t0);  // returns at next start
    t0 = cycCount;
    wr(3'd2, 32'((4 << 16) | 1));    // new L = 7
    measureFrame(len, nAct, nHs, nVs, irqIdx, fld, syn, t1);
    check("R9 current frame keeps old timing", t1 - t0, 35);
    check("R9 next frame uses new timing", len, 49);
    wr(3'd0, 32'b0000);
    waitStopped(stopped);
    check("R6 final stop", stopped, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule